// File: doc/BRIEF.md
# Configurable Multi-Line Edge Detector Bank

This block watches a wide bus of single-bit lines and raises a one-cycle event on every line whose transition matches the edge type programmed for that line. Each line can be set to fire on a low-to-high change, a high-to-low change, or on any change. It can also be silenced, either by a per-line suppression bit or by a reserved mode code. The per-line event vector and a single "something happened" flag go to downstream capture logic.

Software configures the bank through a small synchronous register port. Modes are packed two bits per line into 32-bit bank words, and those words can be written whole. A line-select register paired with a mode-value register lets software change one line's mode: the hardware merges the new field into the right bank word in a single cycle, so two agents that own different lines of the same word never overwrite each other. The address space always reserves room for sixteen bank words. A build with fewer banks accepts writes to the missing words and discards them.

Top module: `edge_bank`

## Requirements
- R1: In the cycle after a sampled transition, a line's event bit is high for exactly one cycle, according to its mode. Mode 2'b00 fires on 0→1, 2'b01 fires on 1→0 and 2'b10 fires on either change. A line that does not change raises no event.
- R2: Mode code 2'b11 is reserved, and a line set to it raises no event on either edge.
- R3: Suppression bit 1 blocks events on its line and bit 0 passes them. Suppression word k sits at address 0x10+k, and its bit j covers line 32k+j. All suppression bits are 1 after reset, and the words read back what was written.
- R4: Bank words sit at addresses 0x00 to 0x0F. Bank words reset to zero, and a whole-word write reads back unchanged.
- R5: The mode of line n is held in bank word n/16, at bits [2*(n%16)+1 : 2*(n%16)]. Giving line 7 mode 2'b01 and line 8 mode 2'b10 leaves bank word 0 at 0x00024000.
- R6: Writes to bank words at or above IMPL_BANKS are accepted and discarded, and those words read as zero. The lines they would cover never raise events, and a select/value write aimed at such a line has no effect.
- R7: The line-select register at address 0x18 holds a line number in bits [7:0]. A write to the mode-value register at address 0x19 replaces only that line's field with bits [1:0] and leaves every other field unchanged. A read of 0x19 returns the selected line's current mode.
- R8: The any-event output is high in exactly those cycles in which at least one event bit is high, including when several lines fire together.
- R9: Addresses 0x1A to 0x3F hold nothing. Writes to them change no register, and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_in | input | NUM_LINES | Monitored lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| events | output | NUM_LINES | Per-line one-cycle event pulses |
| any_event | output | 1 | High when any event bit is high |

## Verification
A table of line, mode, before/after level and suppression setting drives each mode with both edge directions and with no change. This separates the rising, falling and toggle decoding from each other and from the reserved code. Lines are chosen in several bank words, at the last implemented line and past it, so a wrong field offset or a missing bank guard shows up as an event on the wrong line or a missing one. Directed tests then program neighbouring fields through the select/value pair and through whole-word writes, and read back the merged words. This tells a true field merge apart from a whole-word overwrite. Further tests probe unimplemented and empty addresses, and fire two lines in the same cycle.

// File: rtl/edb_pkg.sv
package edb_pkg;

    localparam int LINES_PER_BANK = 16;
    localparam int FIELD_W        = 4;
    localparam int ADDR_W         = 6;
    localparam int MAX_BANK_SLOTS = 16;

    localparam logic [ADDR_W-1:0] ADDR_MASK0 = 6'h10;
    localparam logic [ADDR_W-1:0] ADDR_SEL   = 6'h18;
    localparam logic [ADDR_W-1:0] ADDR_VAL   = 6'h19;

    typedef enum logic [1:0] {
        EM_RISE = 2'b00,
        EM_FALL = 2'b01,
        EM_BOTH = 2'b10,
        EM_RSVD = 2'b11
    } edge_mode_e;

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic hit;
        unique case (mode)
            EM_RISE: hit = cur & ~prev;
            EM_FALL: hit = ~cur & prev;
            EM_BOTH: hit = cur ^ prev;
            EM_RSVD: hit = 1'b0;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/edb_regs.sv
module edb_regs
    import edb_pkg::*;
#(
    parameter int NUM_LINES  = 256,
    parameter int IMPL_BANKS = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output logic [2*NUM_LINES-1:0]  mode_flat,
    output logic [NUM_LINES-1:0]    mask_flat,
    output logic [$clog2(NUM_LINES)-1:0] sel_idx
);

    localparam int MAX_BANKS  = NUM_LINES / LINES_PER_BANK;
    localparam int MASK_WORDS = NUM_LINES / 32;
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int BANK_W     = IDX_W - FIELD_W;

    logic [IDX_W-1:0] sel_q;
    logic             val_hit;
    logic [BANK_W-1:0] sel_bank;
    logic [FIELD_W-1:0] sel_field;

    assign val_hit   = wr_en && (addr == ADDR_VAL);
    assign sel_bank  = sel_q[IDX_W-1 -: BANK_W];
    assign sel_field = sel_q[FIELD_W-1:0];
    assign sel_idx   = sel_q;

    // Line-select register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en && addr == ADDR_SEL)
            sel_q <= wdata[IDX_W-1:0];
    end

    // Bank words: implemented slots hold state, the rest read as zero
    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        if (b < IMPL_BANKS) begin : g_impl
            logic [31:0] word_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (wr_en && addr == ADDR_W'(b))
                    word_q <= wdata;
                else if (val_hit && sel_bank == BANK_W'(b))
                    word_q[{sel_field, 1'b0} +: 2] <= wdata[1:0];
            end
            assign mode_flat[32*b +: 32] = word_q;
        end else begin : g_absent
            assign mode_flat[32*b +: 32] = '0;
        end
    end

    // Suppression words, all ones after reset
    for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
        logic [31:0] mword_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                mword_q <= '1;
            else if (wr_en && addr == ADDR_MASK0 + ADDR_W'(w))
                mword_q <= wdata;
        end
        assign mask_flat[32*w +: 32] = mword_q;
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (addr < ADDR_W'(MAX_BANK_SLOTS)) begin
            if (int'(addr) < MAX_BANKS)
                rdata = mode_flat[32*int'(addr) +: 32];
        end else if (addr >= ADDR_MASK0 && addr < ADDR_MASK0 + ADDR_W'(MASK_WORDS)) begin
            rdata = mask_flat[32*int'(addr - ADDR_MASK0) +: 32];
        end else if (addr == ADDR_SEL) begin
            rdata = 32'(sel_q);
        end else if (addr == ADDR_VAL) begin
            rdata = {30'b0, mode_flat[{sel_q, 1'b0} +: 2]};
        end
    end

endmodule

// File: rtl/edb_detect.sv
module edb_detect
    import edb_pkg::*;
#(
    parameter int NUM_LINES  = 256,
    parameter int IMPL_BANKS = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   lines_in,
    input  logic [2*NUM_LINES-1:0] mode_flat,
    input  logic [NUM_LINES-1:0]   mask_flat,
    output logic [NUM_LINES-1:0]   events
);

    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] evt_q;

    // Sample register tracks the lines through reset as well, so the
    // first compare after reset sees a real previous level.
    always_ff @(posedge clk) begin
        prev_q <= lines_in;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        edge_mode_e line_mode;
        if (i / LINES_PER_BANK < IMPL_BANKS) begin : g_live
            assign line_mode = edge_mode_e'(mode_flat[2*i +: 2]);
        end else begin : g_dead
            logic [1:0] unused_mode;
            assign unused_mode = mode_flat[2*i +: 2];
            assign line_mode   = EM_RSVD;
        end
        assign hit[i] = edge_hit(line_mode, prev_q[i], lines_in[i]) & ~mask_flat[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= '0;
        else
            evt_q <= hit;
    end

    assign events = evt_q;

endmodule

// File: rtl/edge_bank.sv
module edge_bank
    import edb_pkg::*;
#(
    parameter int NUM_LINES  = 256,
    parameter int IMPL_BANKS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic                 reg_wr,
    input  logic [5:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_LINES-1:0] events,
    output logic                 any_event
);

    localparam int IDX_W = $clog2(NUM_LINES);

    logic [2*NUM_LINES-1:0] mode_flat;
    logic [NUM_LINES-1:0]   mask_flat;
    logic [IDX_W-1:0]       sel_idx;

    edb_regs #(
        .NUM_LINES (NUM_LINES),
        .IMPL_BANKS(IMPL_BANKS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .mode_flat(mode_flat),
        .mask_flat(mask_flat),
        .sel_idx  (sel_idx)
    );

    edb_detect #(
        .NUM_LINES (NUM_LINES),
        .IMPL_BANKS(IMPL_BANKS)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (lines_in),
        .mode_flat(mode_flat),
        .mask_flat(mask_flat),
        .events   (events)
    );

    assign any_event = |events;

endmodule

// File: rtl/edge_bank_chk.sv
module edge_bank_chk
    import edb_pkg::*;
#(
    parameter int NUM_LINES  = 256,
    parameter int IMPL_BANKS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] lines_in,
    input logic                 reg_wr,
    input logic [5:0]           reg_addr,
    input logic [31:0]          reg_rdata,
    input logic [NUM_LINES-1:0] events,
    input logic                 any_event,
    input logic [NUM_LINES-1:0] mask_flat,
    input logic [$clog2(NUM_LINES)-1:0] sel_idx
);

    localparam int LIVE_LINES = IMPL_BANKS * LINES_PER_BANK;
    localparam logic [NUM_LINES-1:0] DEAD_LINES =
        (LIVE_LINES >= NUM_LINES) ? '0 : ({NUM_LINES{1'b1}} << LIVE_LINES);

    AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (events & ~($past(lines_in) ^ $past(lines_in, 2))) == '0); // R1

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (events & $past(mask_flat)) == '0); // R3

    AST_DEAD_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (events & DEAD_LINES) == '0); // R6

    AST_DEAD_BANK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < 6'(MAX_BANK_SLOTS) && int'(reg_addr) >= IMPL_BANKS) |-> reg_rdata == '0); // R6

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_SEL) |=> $stable(sel_idx)); // R7

    AST_ANY_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        any_event |-> $past(lines_in) != $past(lines_in, 2)); // R8

    AST_EMPTY_ADDR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_VAL) |-> reg_rdata == '0); // R9

endmodule

bind edge_bank edge_bank_chk #(
    .NUM_LINES (NUM_LINES),
    .IMPL_BANKS(IMPL_BANKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_in (lines_in),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .events   (events),
    .any_event(any_event),
    .mask_flat(mask_flat),
    .sel_idx  (sel_idx)
);

// File: tb/edge_bank_test.sv
module edge_bank_test;

    localparam int N    = 256;
    localparam int IMPL = 12;
    localparam int NV   = 12;

    // {line[7:0], mode[1:0], before, after, suppressed, expect}
    localparam logic [13:0] VEC [NV] = '{
        {8'd3,   2'b00, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd3,   2'b00, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd40,  2'b01, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'd40,  2'b01, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd100, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd100, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'd150, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd150, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd7,   2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'd255, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd191, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'd0,   2'b00, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  lines_in;
    logic          reg_wr;
    logic [5:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  events;
    logic          any_event;
    int            errs   = 0;
    int            checks = 0;
    logic [31:0]   rv;

    always #4 clk = ~clk;

    edge_bank #(.NUM_LINES(N), .IMPL_BANKS(IMPL)) uut (
        .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .events(events), .any_event(any_event)
    );

    task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chkev(string req, logic [N-1:0] exp);
        checks++;
        if (events !== exp || any_event !== (exp != '0)) begin
            errs++;
            $display("FAIL %s: events %h any %b expected %h any %b",
                     req, events, any_event, exp, exp != '0);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lines_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R3 reset state
        chkev("R8 reset events", '0);
        rd(6'h00, rv); chk32("R4 bank0 reset", rv, 32'h0);
        rd(6'h10, rv); chk32("R3 mask0 reset", rv, 32'hFFFF_FFFF);

        // Vector table walk: R1 R2 R3 R6 R8
        for (int i = 0; i < NV; i++) begin
            logic [7:0] ln;
            logic [1:0] md;
            logic       b0, b1, sup, ex;
            logic [N-1:0] expv;
            {ln, md, b0, b1, sup, ex} = VEC[i];
            wr(6'h18, 32'(ln));
            wr(6'h19, 32'(md));
            wr(6'h10 + 6'(ln / 32), sup ? 32'hFFFF_FFFF : ~(32'h1 << (ln % 32)));
            @(negedge clk); lines_in = '0; lines_in[ln] = b0;
            repeat (2) @(negedge clk);
            lines_in[ln] = b1;
            @(negedge clk);
            expv = '0; expv[ln] = ex;
            chkev($sformatf("R1 R2 R3 R6 vector %0d", i), expv);
            @(negedge clk);
            chkev($sformatf("R1 single pulse vector %0d", i), '0);
            wr(6'h10 + 6'(ln / 32), 32'hFFFF_FFFF);
            lines_in = '0;
            repeat (2) @(negedge clk);
        end

        // R8 two lines in one cycle (line 3 rising, line 100 toggle)
        wr(6'h10, ~32'h8);
        wr(6'h13, ~32'h10);
        @(negedge clk);
        lines_in[3] = 1'b1; lines_in[100] = 1'b1;
        @(negedge clk);
        begin
            logic [N-1:0] e2;
            e2 = '0; e2[3] = 1'b1; e2[100] = 1'b1;
            chkev("R8 two lines together", e2);
        end
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h13, 32'hFFFF_FFFF);
        lines_in = '0;
        repeat (2) @(negedge clk);

        // R5 field placement (bank0 fields used above are all 2'b00)
        wr(6'h18, 32'd7);  wr(6'h19, 32'h1);
        wr(6'h18, 32'd8);  wr(6'h19, 32'h2);
        rd(6'h00, rv); chk32("R5 bank0 after lines 7 and 8", rv, 32'h0002_4000);

        // R7 value readback and merge into a full word
        rd(6'h19, rv); chk32("R7 value read line 8", rv, 32'h2);
        wr(6'h01, 32'hFFFF_FFFF);
        rd(6'h01, rv); chk32("R4 bank1 full write", rv, 32'hFFFF_FFFF);
        wr(6'h18, 32'd20); wr(6'h19, 32'h0);
        rd(6'h01, rv); chk32("R7 merge line 20", rv, 32'hFFFF_FCFF);
        rd(6'h18, rv); chk32("R7 select readback", rv, 32'd20);

        // R3 suppression word readback
        wr(6'h11, 32'hA5A5_5A5A);
        rd(6'h11, rv); chk32("R3 mask1 readback", rv, 32'hA5A5_5A5A);

        // R6 unimplemented bank and lines
        wr(6'h0F, 32'h1234_5678);
        rd(6'h0F, rv); chk32("R6 bank15 reads zero", rv, 32'h0);
        wr(6'h18, 32'd255); wr(6'h19, 32'h2);
        rd(6'h19, rv); chk32("R6 line 255 value", rv, 32'h0);

        // R9 empty addresses
        wr(6'h1A, 32'hDEAD_BEEF);
        rd(6'h1A, rv); chk32("R9 read 0x1A", rv, 32'h0);
        rd(6'h3F, rv); chk32("R9 read 0x3F", rv, 32'h0);
        rd(6'h00, rv); chk32("R9 bank0 untouched", rv, 32'h0002_4000);
        rd(6'h11, rv); chk32("R9 mask1 untouched", rv, 32'hA5A5_5A5A);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule